// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two unsigned operands of `WIDTH` bits one bit position per clock, using a single full adder and a carry flip-flop. Operand A sits in an accumulator shift register; as its bits leave at the least significant end, the sum bits enter at the most significant end. After one complete pass the accumulator holds the sum. Operand B sits in a second shift register. While its bits are consumed, the next operand streams in through a serial input, least significant bit first. A new addition can therefore start right after the previous one ends, without a third register.

A `start` pulse, given while the block is idle, clears the carry and enables shifting for exactly `WIDTH` clocks. One cycle after the last shift, `done` pulses and `carryOut` holds the carry out of the most significant position. A clear input empties both registers and the carry.

To accumulate a list of operands, clear the block first. Run one pass while streaming in the first operand: B was empty, so A stays zero. Run a second pass while streaming in the next operand: this copies the first operand into A. Each later pass adds the operand that was streamed in during the pass before it.

Top module: `serial_accum_adder`

## Requirements
- R1: A high `clear` sampled at a clock edge zeroes register A, register B, the carry, `busy` and `done` after that edge. It takes priority over `start` and over shifting.
- R2: A `start` sampled while `busy` is low raises `busy` after that edge. `busy` then stays high for exactly `WIDTH` clock edges, and each of those edges is one shift.
- R3: On each shift edge both registers move right by one position. The full-adder sum of bit 0 of A, bit 0 of B and the stored carry enters bit `WIDTH-1` of A, and the full-adder carry-out is stored.
- R4: On each shift edge, `serialIn` enters bit `WIDTH-1` of B. A pass fed with bit k of an operand on its k-th shift (k counted from 0) leaves that operand in B.
- R5: When A is zero and the carry starts at zero, one pass copies B into A.
- R6: After a pass, `accum` equals (A + B) mod 2^`WIDTH` for the values held before the pass. `carryOut` equals bit `WIDTH` of the full sum A + B.
- R7: `done` is high for exactly one cycle, the cycle right after the final shift edge, which is also the first cycle with `busy` low again.
- R8: A `start` sampled while `busy` is high has no effect. The running pass still ends after its original `WIDTH` shifts and gives the same result.
- R9: While `busy` is low, A, B and the carry hold their values whatever `serialIn` does.
- R10: An active-low `rst_n` asynchronously puts the block in the same state that `clear` produces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of both registers, carry and sequencing |
| start | input | 1 | Begins a pass when idle |
| serialIn | input | 1 | Next operand for B, least significant bit first |
| accum | output | WIDTH | Parallel view of register A |
| carryOut | output | 1 | Carry flip-flop; after a pass, the overflow bit |
| busy | output | 1 | Shift enable; high during the WIDTH shift cycles |
| done | output | 1 | One-cycle pulse after the final shift |

## Verification
The bench builds the block with `WIDTH` = 4. With that width it sweeps every ordered pair of operands through the full sequence of loading, copying and adding, and adds a third operand on top of each sum. This covers every carry chain, including a carry that runs through all positions and the overflow bit. The small width also keeps the exact count of shift cycles, the `done` timing, a `start` issued in the middle of a pass, idle periods with a toggling serial input, and a clear issued in the middle of a pass within a few thousand cycles.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  // Strobes issued by the sequencer to the datapath each cycle.
  typedef struct packed {
    logic clearAll;    // zero both registers and the carry
    logic clearCarry;  // zero the carry only (beginning of a pass)
    logic shiftEn;     // shift both registers one place right
  } sadd_strobes_t;

endpackage

// File: rtl/sadd_shiftreg.sv
module sadd_shiftreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             serIn,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] regQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regQ <= '0;
    end else if (clr) begin
      regQ <= '0;
    end else if (en) begin
      regQ <= {serIn, regQ[WIDTH-1:1]};
    end
  end

  assign q = regQ;

  // R9: without enable or clear the contents hold
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(regQ));

  // R3: a shift moves every bit one place toward the LSB
  a_r3_shift_right: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (regQ[WIDTH-2:0] == $past(regQ[WIDTH-1:1])));

  // R4: a shift places the serial input in the top position
  a_r4_serial_top: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |=> (regQ[WIDTH-1] == $past(serIn)));

endmodule

// File: rtl/sadd_full_adder.sv
module sadd_full_adder (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic cout
);

  always_comb begin
    sum  = x ^ y ^ cin;
    cout = (x & y) | (x & cin) | (y & cin);
  end

endmodule

// File: rtl/sadd_datapath.sv
module sadd_datapath
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sadd_strobes_t    strobes,
  input  logic             serialIn,
  output logic [WIDTH-1:0] accum,
  output logic             carryOut
);

  logic [WIDTH-1:0] aReg;
  logic [WIDTH-1:0] bReg;
  logic             carryQ;
  logic             sumBit;
  logic             coutBit;

  // Accumulator: takes the sum bit at its top as its LSB leaves.
  sadd_shiftreg #(.WIDTH(WIDTH)) u_regA (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (strobes.clearAll),
    .en    (strobes.shiftEn),
    .serIn (sumBit),
    .q     (aReg)
  );

  // Operand B: refilled from the serial input while it is consumed.
  sadd_shiftreg #(.WIDTH(WIDTH)) u_regB (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (strobes.clearAll),
    .en    (strobes.shiftEn),
    .serIn (serialIn),
    .q     (bReg)
  );

  sadd_full_adder u_fa (
    .x    (aReg[0]),
    .y    (bReg[0]),
    .cin  (carryQ),
    .sum  (sumBit),
    .cout (coutBit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carryQ <= 1'b0;
    end else if (strobes.clearAll || strobes.clearCarry) begin
      carryQ <= 1'b0;
    end else if (strobes.shiftEn) begin
      carryQ <= coutBit;
    end
  end

  assign accum    = aReg;
  assign carryOut = carryQ;

  // R1: a clear empties both registers and the carry
  a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearAll |=> (aReg == '0 && bReg == '0 && !carryQ));

  // R3: the new top bit of A and the new carry form the full-adder result
  a_r3_bit_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.shiftEn && !strobes.clearAll) |=>
      ({carryQ, aReg[WIDTH-1]} ==
       2'($past(aReg[0])) + 2'($past(bReg[0])) + 2'($past(carryQ))));

  // R9: the carry holds while nothing is strobed
  a_r9_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobes.shiftEn || strobes.clearAll || strobes.clearCarry) |=> $stable(carryQ));

endmodule

// File: rtl/sadd_control.sv
module sadd_control
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          start,
  output sadd_strobes_t strobes,
  output logic          busy,
  output logic          done
);

  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST  = CW'(1);
  localparam logic [CW-1:0] COUNT = CW'(WIDTH);

  logic [CW-1:0] bitsLeft;
  logic          busyQ;
  logic          doneQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitsLeft <= '0;
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else if (clear) begin
      bitsLeft <= '0;
      busyQ    <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (busyQ) begin
        bitsLeft <= bitsLeft - LAST;
        if (bitsLeft == LAST) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
        end
      end else if (start) begin
        bitsLeft <= COUNT;
        busyQ    <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes.clearAll   = clear;
    strobes.clearCarry = start && !busyQ && !clear;
    strobes.shiftEn    = busyQ && !clear;
  end

  assign busy = busyQ;
  assign done = doneQ;

  // R2: an idle start arms a full pass
  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busyQ && !clear) |=> (busyQ && bitsLeft == COUNT));

  // R2: the remaining count never exceeds the width
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bitsLeft <= COUNT);

  // R7: done lasts one cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ |=> !doneQ);

  // R7: a pass that ends without a clear raises done
  a_r7_end_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && !clear && bitsLeft == LAST) |=> (doneQ && !busyQ));

  // R8: start while busy does not reload the count
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && start && !clear && bitsLeft != LAST) |=> (bitsLeft == $past(bitsLeft) - LAST));

endmodule

// File: rtl/serial_accum_adder.sv
module serial_accum_adder
  import sadd_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             start,
  input  logic             serialIn,
  output logic [WIDTH-1:0] accum,
  output logic             carryOut,
  output logic             busy,
  output logic             done
);

  sadd_strobes_t strobes;

  sadd_control #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  sadd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .serialIn (serialIn),
    .accum    (accum),
    .carryOut (carryOut)
  );

  // R10: the asynchronous reset leaves the block idle and empty
  always_comb begin
    if (!rst_n) begin
      a_r10_reset_state: assert (accum == '0 && !carryOut && !busy && !done);
    end
  end

endmodule

// File: tb/serial_accum_adder_bench.sv
module serial_accum_adder_bench;

  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clear;
  logic         start;
  logic         serialIn;
  logic [W-1:0] accum;
  logic         carryOut;
  logic         busy;
  logic         done;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  serial_accum_adder #(.WIDTH(W)) u_serial_accum_adder (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .start    (start),
    .serialIn (serialIn),
    .accum    (accum),
    .carryOut (carryOut),
    .busy     (busy),
    .done     (done)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One full pass, streaming `feed` into B LSB first. Optionally a start
  // pulse is given in the middle of the pass.
  task automatic doPass(input logic [W-1:0] feed, input bit midStart);
    int busyCount = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < W; k++) begin
      serialIn = feed[k];
      if (midStart && k == 1) start = 1'b1;
      if (busy) busyCount++;
      @(negedge clk);
      start = 1'b0;
    end
    check("R2 busy cycles", busyCount, W);
    check("R7 done after last shift", {busy, done}, 1);
    serialIn = ~feed[0];
    @(negedge clk);
    check("R7 done single", done, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    clear = 1'b0;
    start = 1'b0;
    serialIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset accum", accum, 0);
    check("R10 reset flags", {carryOut, busy, done}, 0);
    rst_n = 1'b1;

    for (int x = 0; x < M; x++) begin
      for (int y = 0; y < M; y++) begin
        int z;
        int tot;
        z = (x * 5 + y * 3 + 1) % M;
        @(negedge clk);
        clear = 1'b1;
        start = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        start = 1'b0;
        check("R1 clear", {carryOut, busy, done, accum}, 0);
        doPass(W'(x), 1'b0);
        check("R6 empty pass", {carryOut, accum}, 0);
        doPass(W'(y), 1'b0);
        check("R5 copy", {carryOut, accum}, x);
        doPass(W'(z), (y % 2) == 1);
        check("R6 R8 sum", accum, (x + y) % M);
        check("R6 overflow", carryOut, (x + y) / M);
        // R9: idle with toggling serial input
        for (int i = 0; i < 3; i++) begin
          serialIn = ~serialIn;
          @(negedge clk);
        end
        check("R9 hold", {carryOut, accum}, ((x + y) / M) * M + (x + y) % M);
        doPass('0, 1'b0);
        tot = (x + y) % M + z;
        check("R4 R6 third operand", {carryOut, accum}, tot);
      end
    end

    // R1: clear in the middle of a pass, then prove B was emptied
    doPass(W'(M - 1), 1'b0);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    serialIn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R1 mid-pass clear", {carryOut, busy, done, accum}, 0);
    doPass(W'(M - 1), 1'b0);
    check("R1 B emptied", {carryOut, accum}, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule